// File: doc/BRIEF.md
# Configurable Macrocell Storage Element

This block models one logic cell of a programmable logic device. It takes a logic input that stands for the sum of product terms, separate set and reset terms, a product-term clock, a bank of global clocks and the value seen on the cell's pin. It produces two results. The first is a feedback value that goes back into the interconnect. The second is a pin output with an enable.

Static configuration inputs choose the following:
- the storage behaviour: pass-through, edge-triggered data, edge-triggered toggle, or level-sensitive latch;
- which clock drives the element, and whether its active sense is inverted;
- the active level of the set term and of the reset term;
- whether the element captures the pin value in place of the logic input;
- the polarity of the pin output.

The whole cell runs on one fast system clock. The global clocks and the product-term clock are treated as sampled signals. A rising transition of the selected clock, after its polarity is applied, is detected between two system-clock cycles, and the element updates on the system-clock edge where that transition is seen. The set and reset terms act on the next system-clock edge whether or not the selected clock moves.

Top module: `mcell_reg`

## Requirements
- R1: While `rst_n` is low, the stored bit clears to 0. After release, with `cfgMode` in a registered mode, `fbOut` reads 0 until the stored bit is changed.
- R2: `cfgMode` 2'd0 is pass-through. `fbOut` equals the selected source (`sumTerm`, or `pinIn` when `cfgInReg` is 1) in the same cycle, with no clock involved.
- R3: `cfgMode` 2'd1 is edge-triggered data. The stored bit takes the source at the first system-clock edge that sees the effective clock at 1 after it was 0. Otherwise the stored bit holds, and falling edges are ignored.
- R4: `cfgMode` 2'd2 is toggle. On an active clock edge the stored bit inverts when the source is 1 and holds when the source is 0.
- R5: `cfgMode` 2'd3 is latch. On every system-clock edge where the effective clock is 1, the stored bit takes the source. While the effective clock is 0 the stored bit holds.
- R6: `cfgClkSel` values 0 to 3 select `gClk[0]` to `gClk[3]`, and value 4 selects `ptClk`. Transitions on clocks that are not selected have no effect.
- R7: With `cfgClkInv` at 1, the effective clock is the selected clock inverted. A falling transition of the raw clock is then the active edge, and a rising one is ignored.
- R8: In registered modes, a reset term with `rstTerm` XOR `cfgRstInv` equal to 1 clears the stored bit at the next system-clock edge. A set term with `setTerm` XOR `cfgSetInv` equal to 1 sets the stored bit at that edge. Neither needs a clock transition.
- R9: When the set term and the reset term are active together, the stored bit clears.
- R10: With `cfgInReg` at 1, the source is `pinIn` instead of `sumTerm`, in every mode.
- R11: With `cfgInReg` at 0, `pinIn` has no effect on `fbOut`.
- R12: With `pinOe` at 1, `pinDrive` is 1 and `pinOut` equals `fbOut` XOR `cfgOutInv`.
- R13: With `pinOe` at 0, `pinDrive` is 0 and `pinOut` is 0, whatever the value of `fbOut`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all inputs |
| rst_n | input | 1 | Active-low synchronous reset |
| cfgMode | input | 2 | Storage behaviour: 0 pass-through, 1 data, 2 toggle, 3 latch |
| cfgClkSel | input | 3 | Clock choice: 0 to 3 global, 4 product-term |
| cfgClkInv | input | 1 | Invert the selected clock |
| cfgSetInv | input | 1 | Set term is active low when 1 |
| cfgRstInv | input | 1 | Reset term is active low when 1 |
| cfgInReg | input | 1 | Capture the pin value instead of the logic input |
| cfgOutInv | input | 1 | Invert the pin output |
| sumTerm | input | 1 | Logic input (sum of product terms) |
| setTerm | input | 1 | Set product term |
| rstTerm | input | 1 | Reset product term |
| ptClk | input | 1 | Product-term clock |
| gClk | input | 4 | Global clocks |
| pinIn | input | 1 | Value seen on the cell's pin |
| pinOe | input | 1 | Pin output enable |
| fbOut | output | 1 | Feedback value to the interconnect |
| pinOut | output | 1 | Pin output value, after polarity |
| pinDrive | output | 1 | Pin is driven when 1 |

## Verification
The hold assertion assumes that a change to the clock choice or to the clock inversion happens in a cycle with no clock transition. Such a change alters the effective clock and is then seen as an edge. The assertion therefore excludes any cycle in which either setting moves. The stimulus applies any change to the clock settings together with raw clock levels that keep the effective clock where it was.

The set and reset assertions expect the mode to stay registered into the next cycle. They also require that the bench does not switch to pass-through in the cycle after a set or a reset. All configuration is changed on the falling system-clock edge, so every change is settled before it is sampled.

// File: rtl/mcell_pkg.sv
package mcell_pkg;

  // Storage behaviour selected by cfgMode
  typedef enum logic [1:0] {
    MODE_COMB  = 2'd0,
    MODE_DFF   = 2'd1,
    MODE_TFF   = 2'd2,
    MODE_LATCH = 2'd3
  } cellMode_e;

  // Strobes from clock/override control to the storage datapath
  typedef struct packed {
    logic edgeHit;   // active transition of effective clock seen this cycle
    logic gateOpen;  // effective clock level is high
    logic forceHigh; // set override active (and reset not)
    logic forceLow;  // reset override active
  } cellStrobe_t;

endpackage

// File: rtl/mcell_clkctl.sv
module mcell_clkctl
  import mcell_pkg::*;
#(
  parameter int NUM_GCLK = 4,
  localparam int SEL_W = $clog2(NUM_GCLK + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SEL_W-1:0]    cfgClkSel,
  input  logic                cfgClkInv,
  input  logic                cfgSetInv,
  input  logic                cfgRstInv,
  input  logic                setTerm,
  input  logic                rstTerm,
  input  logic                ptClk,
  input  logic [NUM_GCLK-1:0] gClk,
  output cellStrobe_t         strobe
);

  logic selRaw;
  logic effClk;
  logic prevEff;
  logic setAct;
  logic rstAct;

  // Pick one global clock by index; any other value selects the product-term clock
  always_comb begin
    selRaw = ptClk;
    for (int i = 0; i < NUM_GCLK; i++) begin
      if (cfgClkSel == SEL_W'(i)) selRaw = gClk[i];
    end
  end

  assign effClk = selRaw ^ cfgClkInv;

  // Previous effective level; reset high so a high level at release is not an edge
  always_ff @(posedge clk) begin
    if (!rst_n) prevEff <= 1'b1;
    else        prevEff <= effClk;
  end

  assign setAct = setTerm ^ cfgSetInv;
  assign rstAct = rstTerm ^ cfgRstInv;

  always_comb begin
    strobe.edgeHit   = effClk & ~prevEff;
    strobe.gateOpen  = effClk;
    strobe.forceLow  = rstAct;
    strobe.forceHigh = setAct & ~rstAct;
  end

endmodule

// File: rtl/mcell_store.sv
module mcell_store
  import mcell_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  cfgMode,
  input  logic        cfgInReg,
  input  logic        cfgOutInv,
  input  logic        sumTerm,
  input  logic        pinIn,
  input  logic        pinOe,
  input  cellStrobe_t strobe,
  output logic        fbOut,
  output logic        pinOut,
  output logic        pinDrive
);

  cellMode_e mode;
  logic      dataSrc;
  logic      stateQ;
  logic      resultVal;

  assign mode    = cellMode_e'(cfgMode);
  assign dataSrc = cfgInReg ? pinIn : sumTerm;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stateQ <= 1'b0;
    end else if (strobe.forceLow) begin
      stateQ <= 1'b0;
    end else if (strobe.forceHigh) begin
      stateQ <= 1'b1;
    end else begin
      unique case (mode)
        MODE_DFF:   if (strobe.edgeHit) stateQ <= dataSrc;
        MODE_TFF:   if (strobe.edgeHit && dataSrc) stateQ <= ~stateQ;
        MODE_LATCH: if (strobe.gateOpen) stateQ <= dataSrc;
        default:    stateQ <= stateQ;
      endcase
    end
  end

  // Feedback is taken before the pin polarity mux, apart from the pin input path
  assign resultVal = (mode == MODE_COMB) ? dataSrc : stateQ;
  assign fbOut     = resultVal;
  assign pinDrive  = pinOe;
  assign pinOut    = pinOe ? (resultVal ^ cfgOutInv) : 1'b0;

endmodule

// File: rtl/mcell_reg.sv
module mcell_reg
  import mcell_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] cfgMode,
  input  logic [2:0] cfgClkSel,
  input  logic       cfgClkInv,
  input  logic       cfgSetInv,
  input  logic       cfgRstInv,
  input  logic       cfgInReg,
  input  logic       cfgOutInv,
  input  logic       sumTerm,
  input  logic       setTerm,
  input  logic       rstTerm,
  input  logic       ptClk,
  input  logic [3:0] gClk,
  input  logic       pinIn,
  input  logic       pinOe,
  output logic       fbOut,
  output logic       pinOut,
  output logic       pinDrive
);

  cellStrobe_t strobe;

  mcell_clkctl #(.NUM_GCLK(4)) u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfgClkSel (cfgClkSel),
    .cfgClkInv (cfgClkInv),
    .cfgSetInv (cfgSetInv),
    .cfgRstInv (cfgRstInv),
    .setTerm   (setTerm),
    .rstTerm   (rstTerm),
    .ptClk     (ptClk),
    .gClk      (gClk),
    .strobe    (strobe)
  );

  mcell_store u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfgMode   (cfgMode),
    .cfgInReg  (cfgInReg),
    .cfgOutInv (cfgOutInv),
    .sumTerm   (sumTerm),
    .pinIn     (pinIn),
    .pinOe     (pinOe),
    .strobe    (strobe),
    .fbOut     (fbOut),
    .pinOut    (pinOut),
    .pinDrive  (pinDrive)
  );

endmodule

// File: rtl/mcell_chk.sv
module mcell_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] cfgMode,
  input logic [2:0] cfgClkSel,
  input logic       cfgClkInv,
  input logic       cfgSetInv,
  input logic       cfgRstInv,
  input logic       cfgInReg,
  input logic       cfgOutInv,
  input logic       sumTerm,
  input logic       setTerm,
  input logic       rstTerm,
  input logic       ptClk,
  input logic [3:0] gClk,
  input logic       pinIn,
  input logic       pinOe,
  input logic       fbOut,
  input logic       pinOut,
  input logic       pinDrive
);

  logic setOn;
  logic rstOn;
  assign setOn = setTerm ^ cfgSetInv;
  assign rstOn = rstTerm ^ cfgRstInv;

  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rstOn && cfgMode != 2'd0) |=> (cfgMode == 2'd0 || !fbOut)); // R8

  AST_SET_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    (setOn && !rstOn && cfgMode != 2'd0) |=> (cfgMode == 2'd0 || fbOut)); // R8

  AST_RESET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (setOn && rstOn && cfgMode != 2'd0) |=> (cfgMode == 2'd0 || !fbOut)); // R9

  AST_EDGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ((cfgMode == 2'd1 || cfgMode == 2'd2) && !setOn && !rstOn &&
     $stable(gClk) && $stable(ptClk) && $stable(cfgClkSel) && $stable(cfgClkInv))
    |=> (!(cfgMode == 2'd1 || cfgMode == 2'd2) || $stable(fbOut))); // R3

  AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    (cfgMode == 2'd0 && !cfgInReg) |-> (fbOut == sumTerm)); // R2

  AST_PIN_POLARITY: assert property (@(posedge clk) disable iff (!rst_n)
    pinOe |-> (pinDrive && pinOut == (fbOut ^ cfgOutInv))); // R12

  AST_PIN_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    !pinOe |-> (!pinDrive && !pinOut)); // R13

endmodule

bind mcell_reg mcell_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfgMode   (cfgMode),
  .cfgClkSel (cfgClkSel),
  .cfgClkInv (cfgClkInv),
  .cfgSetInv (cfgSetInv),
  .cfgRstInv (cfgRstInv),
  .cfgInReg  (cfgInReg),
  .cfgOutInv (cfgOutInv),
  .sumTerm   (sumTerm),
  .setTerm   (setTerm),
  .rstTerm   (rstTerm),
  .ptClk     (ptClk),
  .gClk      (gClk),
  .pinIn     (pinIn),
  .pinOe     (pinOe),
  .fbOut     (fbOut),
  .pinOut    (pinOut),
  .pinDrive  (pinDrive)
);

// File: tb/sim_mcell_reg.sv
`timescale 1ns/1ps
module sim_mcell_reg;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] cfgMode = 2'd1;
  logic [2:0] cfgClkSel = 3'd0;
  logic       cfgClkInv = 1'b0;
  logic       cfgSetInv = 1'b0;
  logic       cfgRstInv = 1'b0;
  logic       cfgInReg = 1'b0;
  logic       cfgOutInv = 1'b0;
  logic       sumTerm = 1'b0;
  logic       setTerm = 1'b0;
  logic       rstTerm = 1'b0;
  logic       ptClk = 1'b0;
  logic [3:0] gClk = 4'd0;
  logic       pinIn = 1'b0;
  logic       pinOe = 1'b0;
  logic       fbOut;
  logic       pinOut;
  logic       pinDrive;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  typedef struct {
    logic  fb;
    logic  pin;
    logic  drv;
    string tag;
  } expItem_t;

  expItem_t sbQueue[$];

  always #2 clk = ~clk; // 250 MHz

  mcell_reg u0 (
    .clk(clk), .rst_n(rst_n), .cfgMode(cfgMode), .cfgClkSel(cfgClkSel),
    .cfgClkInv(cfgClkInv), .cfgSetInv(cfgSetInv), .cfgRstInv(cfgRstInv),
    .cfgInReg(cfgInReg), .cfgOutInv(cfgOutInv), .sumTerm(sumTerm),
    .setTerm(setTerm), .rstTerm(rstTerm), .ptClk(ptClk), .gClk(gClk),
    .pinIn(pinIn), .pinOe(pinOe), .fbOut(fbOut), .pinOut(pinOut),
    .pinDrive(pinDrive)
  );

  // Driver side: inputs were just set at a falling edge; queue the result due after the next rising edge
  task automatic expect3(input logic fb, input logic pin, input logic drv, input string tag);
    expItem_t it;
    it.fb = fb; it.pin = pin; it.drv = drv; it.tag = tag;
    sbQueue.push_back(it);
    @(negedge clk);
  endtask

  // Monitor: pop one expectation per cycle, just after the rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sbQueue.size() > 0) begin
        expItem_t it;
        it = sbQueue.pop_front();
        checks++;
        if (fbOut !== it.fb || pinOut !== it.pin || pinDrive !== it.drv) begin
          errors++;
          $display("FAIL %s: got fb=%b pin=%b drv=%b expected fb=%b pin=%b drv=%b",
                   it.tag, fbOut, pinOut, pinDrive, it.fb, it.pin, it.drv);
        end
      end
    end
  end

  initial begin
    #200000;
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    expect3(0, 0, 0, "R1 reset state");

    // D mode on gClk[0]
    pinOe = 1'b1;
    expect3(0, 0, 1, "R12 enable drives pin");
    sumTerm = 1'b1;
    expect3(0, 0, 1, "R3 hold without edge");
    gClk[0] = 1'b1;
    expect3(1, 1, 1, "R3 capture on rise");
    sumTerm = 1'b0;
    expect3(1, 1, 1, "R3 clock stays high");
    gClk[0] = 1'b0;
    expect3(1, 1, 1, "R3 fall ignored");
    gClk[0] = 1'b1;
    expect3(0, 0, 1, "R3 capture zero");
    gClk[0] = 1'b0;
    expect3(0, 0, 1, "R3 idle");

    // clock selection
    cfgClkSel = 3'd2; sumTerm = 1'b1; gClk[0] = 1'b1;
    expect3(0, 0, 1, "R6 unselected clock ignored");
    gClk[0] = 1'b0; gClk[2] = 1'b1;
    expect3(1, 1, 1, "R6 selected gClk2 edge");
    cfgClkSel = 3'd4; gClk[2] = 1'b0; sumTerm = 1'b0;
    expect3(1, 1, 1, "R6 switch to product-term clock");
    ptClk = 1'b1;
    expect3(0, 0, 1, "R6 ptClk edge");
    ptClk = 1'b0;
    expect3(0, 0, 1, "R6 ptClk low");

    // inverted clock
    cfgClkInv = 1'b1; ptClk = 1'b1; sumTerm = 1'b1;
    expect3(0, 0, 1, "R7 inversion set, no edge");
    ptClk = 1'b0;
    expect3(1, 1, 1, "R7 falling raw edge captures");
    sumTerm = 1'b0; ptClk = 1'b1;
    expect3(1, 1, 1, "R7 rising raw edge ignored");
    ptClk = 1'b0;
    expect3(0, 0, 1, "R7 falling raw edge captures zero");

    // toggle mode
    cfgMode = 2'd2; sumTerm = 1'b1; ptClk = 1'b1;
    expect3(0, 0, 1, "R4 no edge");
    ptClk = 1'b0;
    expect3(1, 1, 1, "R4 toggle up");
    ptClk = 1'b1;
    expect3(1, 1, 1, "R4 between edges");
    ptClk = 1'b0;
    expect3(0, 0, 1, "R4 toggle down");
    sumTerm = 1'b0; ptClk = 1'b1;
    expect3(0, 0, 1, "R4 idle");
    ptClk = 1'b0;
    expect3(0, 0, 1, "R4 hold when source zero");

    // latch mode on gClk[1]
    cfgClkInv = 1'b0; cfgClkSel = 3'd1; ptClk = 1'b0;
    expect3(0, 0, 1, "R6 reselect global");
    cfgMode = 2'd3; sumTerm = 1'b1;
    expect3(0, 0, 1, "R5 closed holds");
    gClk[1] = 1'b1;
    expect3(1, 1, 1, "R5 open follows");
    sumTerm = 1'b0;
    expect3(0, 0, 1, "R5 open follows low");
    sumTerm = 1'b1;
    expect3(1, 1, 1, "R5 open follows high");
    gClk[1] = 1'b0; sumTerm = 1'b0;
    expect3(1, 1, 1, "R5 close holds");
    expect3(1, 1, 1, "R5 still holding");

    // set / reset
    cfgMode = 2'd1;
    rstTerm = 1'b1;
    expect3(0, 0, 1, "R8 reset without clock");
    rstTerm = 1'b0;
    expect3(0, 0, 1, "R8 reset released");
    setTerm = 1'b1;
    expect3(1, 1, 1, "R8 set without clock");
    setTerm = 1'b0;
    expect3(1, 1, 1, "R8 set released");
    cfgRstInv = 1'b1;
    expect3(0, 0, 1, "R8 active-low reset asserted");
    rstTerm = 1'b1;
    expect3(0, 0, 1, "R8 active-low reset idle");
    cfgSetInv = 1'b1;
    expect3(1, 1, 1, "R8 active-low set asserted");
    setTerm = 1'b1;
    expect3(1, 1, 1, "R8 active-low set idle");
    rstTerm = 1'b0; setTerm = 1'b0;
    expect3(0, 0, 1, "R9 reset beats set");
    rstTerm = 1'b1; setTerm = 1'b1;
    expect3(0, 0, 1, "R9 both released");
    cfgSetInv = 1'b0; cfgRstInv = 1'b0; setTerm = 1'b0; rstTerm = 1'b0;
    expect3(0, 0, 1, "R8 polarity restored");

    // input register
    cfgInReg = 1'b1; pinIn = 1'b1; sumTerm = 1'b0; gClk[1] = 1'b1;
    expect3(1, 1, 1, "R10 captures pin");
    gClk[1] = 1'b0;
    expect3(1, 1, 1, "R10 hold");
    pinIn = 1'b0; sumTerm = 1'b1; gClk[1] = 1'b1;
    expect3(0, 0, 1, "R10 ignores logic input");
    gClk[1] = 1'b0;
    expect3(0, 0, 1, "R10 idle");

    // pass-through and feedback independence
    cfgInReg = 1'b0; cfgMode = 2'd0; sumTerm = 1'b1;
    expect3(1, 1, 1, "R2 pass high");
    sumTerm = 1'b0;
    expect3(0, 0, 1, "R2 pass low");
    pinIn = 1'b1;
    expect3(0, 0, 1, "R11 pin input ignored");
    cfgMode = 2'd1; gClk[1] = 1'b1;
    expect3(0, 0, 1, "R11 registered ignores pin");
    gClk[1] = 1'b0; pinIn = 1'b0;
    cfgMode = 2'd0;
    expect3(0, 0, 1, "R2 back to pass");

    // pin polarity and enable
    cfgOutInv = 1'b1; sumTerm = 1'b1;
    expect3(1, 0, 1, "R12 inverted high");
    sumTerm = 1'b0;
    expect3(0, 1, 1, "R12 inverted low");
    pinOe = 1'b0;
    expect3(0, 0, 0, "R13 released pin");
    sumTerm = 1'b1;
    expect3(1, 0, 0, "R13 released pin with high result");

    repeat (2) @(negedge clk);
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule